// File: doc/BRIEF.md
# Timed-Output Event Staging Register Bank

This block is the software-facing staging area for one output event of a timed-output channel. Software fills in a channel selector, a wide timestamp, an address field and a wide data field through a simple register bus. It then commits the event, and the block presents the whole event on a one-cycle output interface that the downstream queue consumes. Reads return the staged contents and a status word fed from the downstream side.

The data field is a row of 32-bit slots. The highest-numbered slot holds the least significant word, so a software list of words is written from the top slot downward. Every write to a timestamp word zeroes the address and every data slot. An event that carries fewer words than the field holds is therefore zero-padded, and software never writes the unused slots. Committing leaves every staged field as it is, so the same event can be sent to several channels by changing only the channel selector between commits.

The write side has several lanes, and each lane can write one register in every cycle. Lane writes that meet in one cycle are resolved by fixed priority rules. The read side is combinational.

Top module: `evt_stage_regs`

## Requirements
- R1: After reset every register offset reads zero and `ev_valid` is low.
- R2: A lane write stores its word at the next clock edge, and a read then returns it. The offsets are: channel at 0, timestamp upper word at 1, timestamp lower word at 2, address at 3, commit at 4, status at 5, and data slots at 8 to 11. Bits above a field's width read as zero.
- R3: A write of either timestamp word on any lane zeroes the address and all four data slots at the same clock edge.
- R4: A write to the address or to a data slot in the same cycle as a timestamp write on another lane stores the written value, not zero.
- R5: When two lanes write the same offset in the same cycle, the higher-numbered lane's value is stored.
- R6: A write with bit 0 set to offset 4 raises `ev_valid` for exactly the next cycle. The event carries the channel, timestamp, address and data as they stood before that edge, not counting writes made in the same cycle. A write with bit 0 clear produces no pulse.
- R7: A commit leaves every staged field unchanged. Repeated commits that differ only in the channel selector send the same timestamp, address and data.
- R8: Data slot k drives `ev_data[(3-k')*32 +: 32]`, where k' is k minus 8. Slot 11 is the least significant word. A single word written to slot 11 after a timestamp write yields an event whose upper 96 bits are zero.
- R9: Offset 5 reads `dn_full` in bit 0 and `dn_underflow` in bit 1, in the same cycle they are applied. Bits 31 to 2 read zero.
- R10: Writes to unmapped offsets and to offset 5 change no register. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 2 | Per-lane write strobe |
| wr_addr | input | 2x5 | Per-lane register offset |
| wr_data | input | 2x32 | Per-lane write word |
| rd_addr | input | 5 | Read offset |
| rd_data | output | 32 | Combinational read word |
| dn_full | input | 1 | Downstream queue full |
| dn_underflow | input | 1 | Downstream underflow flag |
| ev_valid | output | 1 | One-cycle event pulse |
| ev_chan | output | 8 | Event channel |
| ev_ts | output | 64 | Event timestamp |
| ev_addr | output | 16 | Event address |
| ev_data | output | 128 | Event data |

## Verification
Two functions can meet in one clock edge. The first is the timestamp-triggered clear against a direct write to a cleared field. The second is a commit against a write that changes the staged event. The bench provokes both by driving a timestamp write on lane 0 together with a data or address write on lane 1, and a commit on one lane together with a data write on the other. A behavioural model applies capture first, then the clear, then lane writes in order. The model is compared with the event outputs and the read port on every clock.

// File: rtl/evt_stage_pkg.sv
package evt_stage_pkg;
   localparam int BUS_W          = 32;
   localparam int STAT_W         = 5;
   localparam int STAT_FULL_BIT  = 0;
   localparam int STAT_UNDER_BIT = 1;
endpackage

// File: rtl/evt_field_reg.sv
module evt_field_reg
   import evt_stage_pkg::*;
#(
   parameter int          W      = 32,
   parameter int          AW     = 5,
   parameter int          LANES  = 2,
   parameter int unsigned OFF    = 0,
   parameter bit          CLR_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            lane_we,
   input  logic [LANES-1:0][AW-1:0]    lane_addr,
   input  logic [LANES-1:0][BUS_W-1:0] lane_data,
   input  logic                        clr,
   output logic [W-1:0]                q
);
   initial begin
      if (W < 1 || W > BUS_W) $fatal(1, "field width out of range");
   end

   logic         hit;
   logic [W-1:0] win;

   // later lanes override earlier ones
   always_comb begin
      hit = 1'b0;
      win = q;
      for (int i = 0; i < LANES; i++) begin
         if (lane_we[i] && lane_addr[i] == AW'(OFF)) begin
            hit = 1'b1;
            win = lane_data[i][W-1:0];
         end
      end
   end

   generate
      if (CLR_EN) begin : g_clearable
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= win;
            else if (clr) q <= '0;
         end

         assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !hit) |=> (q == '0));
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= win;
         end
      end
   endgenerate

   // top lane wins over lower lanes (R5) and over the clear (R4)
   assert_top_lane_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we[LANES-1] && lane_addr[LANES-1] == AW'(OFF))
      |=> (q == $past(lane_data[LANES-1][W-1:0])));
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
   import evt_stage_pkg::*;
#(
   parameter int AW         = 5,
   parameter int CHAN_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int TS_WORDS   = 2,
   parameter int DATA_WORDS = 4,
   parameter int CHAN_OFF   = 0,
   parameter int TS_OFF     = 1,
   parameter int ADDR_OFF   = 3,
   parameter int STAT_OFF   = 5,
   parameter int DATA_BASE  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [AW-1:0]                    rd_addr,
   input  logic [CHAN_W-1:0]                chan,
   input  logic [TS_WORDS-1:0][BUS_W-1:0]   ts_slots,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_WORDS-1:0][BUS_W-1:0] data_slots,
   input  logic                             dn_full,
   input  logic                             dn_underflow,
   output logic [BUS_W-1:0]                 rd_data
);
   logic mapped;

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(CHAN_OFF)) rd_data = BUS_W'(chan);
      if (rd_addr == AW'(ADDR_OFF)) rd_data = BUS_W'(addr);
      if (rd_addr == AW'(STAT_OFF)) begin
         rd_data[STAT_FULL_BIT]  = dn_full;
         rd_data[STAT_UNDER_BIT] = dn_underflow;
      end
      for (int j = 0; j < TS_WORDS; j++)
         if (rd_addr == AW'(TS_OFF + j)) rd_data = ts_slots[j];
      for (int k = 0; k < DATA_WORDS; k++)
         if (rd_addr == AW'(DATA_BASE + k)) rd_data = data_slots[k];
   end

   // offset decode kept apart from the data path for the checker
   always_comb begin
      mapped = (int'(rd_addr) <= STAT_OFF) ||
               (int'(rd_addr) >= DATA_BASE && int'(rd_addr) < DATA_BASE + DATA_WORDS);
   end

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rd_data == '0));

   assert_status_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(STAT_OFF)) |-> (rd_data[BUS_W-1:STAT_UNDER_BIT+1] == '0));
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
   parameter int CHAN_W = 8,
   parameter int TS_W   = 64,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CHAN_W-1:0] st_chan,
   input  logic [TS_W-1:0]   st_ts,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   output logic              ev_valid,
   output logic [CHAN_W-1:0] ev_chan,
   output logic [TS_W-1:0]   ev_ts,
   output logic [ADDR_W-1:0] ev_addr,
   output logic [DATA_W-1:0] ev_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_valid <= 1'b0;
         ev_chan  <= '0;
         ev_ts    <= '0;
         ev_addr  <= '0;
         ev_data  <= '0;
      end else begin
         ev_valid <= fire;
         if (fire) begin
            ev_chan <= st_chan;
            ev_ts   <= st_ts;
            ev_addr <= st_addr;
            ev_data <= st_data;
         end
      end
   end

   assert_event_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (ev_valid && ev_chan == $past(st_chan) && ev_ts == $past(st_ts) &&
                ev_addr == $past(st_addr) && ev_data == $past(st_data)));

   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !ev_valid);
endmodule

// File: rtl/evt_stage_regs.sv
module evt_stage_regs
   import evt_stage_pkg::*;
#(
   parameter int DATA_WORDS = 4,
   parameter int ADDR_W     = 16,
   parameter int TS_W       = 64,
   parameter int CHAN_W     = 8,
   parameter int WR_LANES   = 2,
   parameter int REG_AW     = 5,
   parameter int DATA_BASE  = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [WR_LANES-1:0]                  wr_en,
   input  logic [WR_LANES-1:0][REG_AW-1:0]      wr_addr,
   input  logic [WR_LANES-1:0][BUS_W-1:0]       wr_data,
   input  logic [REG_AW-1:0]                    rd_addr,
   output logic [BUS_W-1:0]                     rd_data,
   input  logic                                 dn_full,
   input  logic                                 dn_underflow,
   output logic                                 ev_valid,
   output logic [CHAN_W-1:0]                    ev_chan,
   output logic [TS_W-1:0]                      ev_ts,
   output logic [ADDR_W-1:0]                    ev_addr,
   output logic [DATA_WORDS*BUS_W-1:0]          ev_data
);
   localparam int TS_WORDS   = TS_W / BUS_W;
   localparam int CHAN_OFF   = 0;
   localparam int TS_OFF     = 1;
   localparam int ADDR_OFF   = TS_OFF + TS_WORDS;
   localparam int COMMIT_OFF = ADDR_OFF + 1;
   localparam int STAT_OFF   = COMMIT_OFF + 1;
   localparam int DATA_W     = DATA_WORDS * BUS_W;

   initial begin
      if (TS_W % BUS_W != 0 || TS_WORDS < 1) $fatal(1, "timestamp must be whole bus words");
      if (ADDR_W < 1 || ADDR_W > BUS_W)      $fatal(1, "address width out of range");
      if (CHAN_W < 1 || CHAN_W > BUS_W)      $fatal(1, "channel width out of range");
      if (WR_LANES < 1)                      $fatal(1, "need a write lane");
      if (DATA_BASE <= STAT_OFF)             $fatal(1, "data slots overlap control offsets");
      if (DATA_BASE + DATA_WORDS > (1 << REG_AW)) $fatal(1, "offset space too small");
   end

   // lane decode
   logic ts_hit, commit, other_wr;
   always_comb begin
      ts_hit   = 1'b0;
      commit   = 1'b0;
      other_wr = 1'b0;
      for (int i = 0; i < WR_LANES; i++) begin
         if (wr_en[i]) begin
            if (int'(wr_addr[i]) >= TS_OFF && int'(wr_addr[i]) < TS_OFF + TS_WORDS)
               ts_hit = 1'b1;
            if (wr_addr[i] == REG_AW'(COMMIT_OFF)) begin
               if (wr_data[i][0]) commit = 1'b1;
            end else begin
               other_wr = 1'b1;
            end
         end
      end
   end

   logic [CHAN_W-1:0]                    st_chan;
   logic [ADDR_W-1:0]                    st_addr;
   logic [TS_WORDS-1:0][BUS_W-1:0]       ts_slots;
   logic [DATA_WORDS-1:0][BUS_W-1:0]     data_slots;
   logic [TS_W-1:0]                      st_ts;
   logic [DATA_W-1:0]                    st_data;

   evt_field_reg #(.W(CHAN_W), .AW(REG_AW), .LANES(WR_LANES), .OFF(CHAN_OFF), .CLR_EN(1'b0))
   u_chan (.clk(clk), .rst_n(rst_n), .lane_we(wr_en), .lane_addr(wr_addr),
           .lane_data(wr_data), .clr(1'b0), .q(st_chan));

   evt_field_reg #(.W(ADDR_W), .AW(REG_AW), .LANES(WR_LANES), .OFF(ADDR_OFF), .CLR_EN(1'b1))
   u_addr (.clk(clk), .rst_n(rst_n), .lane_we(wr_en), .lane_addr(wr_addr),
           .lane_data(wr_data), .clr(ts_hit), .q(st_addr));

   // slot j holds significance TS_WORDS-1-j: lowest word sits at the top slot
   genvar gj;
   generate
      for (gj = 0; gj < TS_WORDS; gj++) begin : g_ts
         evt_field_reg #(.W(BUS_W), .AW(REG_AW), .LANES(WR_LANES), .OFF(TS_OFF + gj),
                         .CLR_EN(1'b0))
         u_ts (.clk(clk), .rst_n(rst_n), .lane_we(wr_en), .lane_addr(wr_addr),
               .lane_data(wr_data), .clr(1'b0), .q(ts_slots[gj]));
         assign st_ts[(TS_WORDS-1-gj)*BUS_W +: BUS_W] = ts_slots[gj];
      end
      for (gj = 0; gj < DATA_WORDS; gj++) begin : g_data
         evt_field_reg #(.W(BUS_W), .AW(REG_AW), .LANES(WR_LANES), .OFF(DATA_BASE + gj),
                         .CLR_EN(1'b1))
         u_dat (.clk(clk), .rst_n(rst_n), .lane_we(wr_en), .lane_addr(wr_addr),
                .lane_data(wr_data), .clr(ts_hit), .q(data_slots[gj]));
         assign st_data[(DATA_WORDS-1-gj)*BUS_W +: BUS_W] = data_slots[gj];
      end
   endgenerate

   evt_read_mux #(
      .AW(REG_AW), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W), .TS_WORDS(TS_WORDS),
      .DATA_WORDS(DATA_WORDS), .CHAN_OFF(CHAN_OFF), .TS_OFF(TS_OFF),
      .ADDR_OFF(ADDR_OFF), .STAT_OFF(STAT_OFF), .DATA_BASE(DATA_BASE)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .chan(st_chan), .ts_slots(ts_slots),
      .addr(st_addr), .data_slots(data_slots), .dn_full(dn_full),
      .dn_underflow(dn_underflow), .rd_data(rd_data)
   );

   evt_capture #(.CHAN_W(CHAN_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .fire(commit), .st_chan(st_chan), .st_ts(st_ts),
      .st_addr(st_addr), .st_data(st_data), .ev_valid(ev_valid), .ev_chan(ev_chan),
      .ev_ts(ev_ts), .ev_addr(ev_addr), .ev_data(ev_data)
   );

   // a bare commit leaves the staged event untouched
   assert_commit_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !other_wr) |=> (st_data == $past(st_data) && st_ts == $past(st_ts) &&
                                 st_addr == $past(st_addr) && st_chan == $past(st_chan)));
endmodule

// File: tb/evt_stage_regs_test.sv
module evt_stage_regs_test;
   localparam int CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       wr_en = '0;
   logic [1:0][4:0]  wr_addr = '0;
   logic [1:0][31:0] wr_data = '0;
   logic [4:0]       rd_addr = '0;
   logic [31:0]      rd_data;
   logic             dn_full = 1'b0;
   logic             dn_underflow = 1'b0;
   logic             ev_valid;
   logic [7:0]       ev_chan;
   logic [63:0]      ev_ts;
   logic [15:0]      ev_addr;
   logic [127:0]     ev_data;

   int checks = 0;
   int failures = 0;

   // behavioural model
   logic [7:0]   m_chan = '0;
   logic [63:0]  m_ts = '0;
   logic [15:0]  m_addr = '0;
   logic [31:0]  m_data [4] = '{default: '0};
   logic         m_ev_valid = 1'b0;
   logic [7:0]   m_ev_chan = '0;
   logic [63:0]  m_ev_ts = '0;
   logic [15:0]  m_ev_addr = '0;
   logic [127:0] m_ev_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_stage_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .dn_full(dn_full), .dn_underflow(dn_underflow),
      .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_ts(ev_ts), .ev_addr(ev_addr),
      .ev_data(ev_data)
   );

   function automatic logic [127:0] m_packed();
      return {m_data[0], m_data[1], m_data[2], m_data[3]};
   endfunction

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0:  return {24'b0, m_chan};
         1:  return m_ts[63:32];
         2:  return m_ts[31:0];
         3:  return {16'b0, m_addr};
         5:  return {30'b0, dn_underflow, dn_full};
         8, 9, 10, 11: return m_data[a-8];
         default: return 32'b0;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // model of one edge: capture, then clear, then lanes in order
   task automatic model_edge();
      logic cm = 1'b0;
      logic tw = 1'b0;
      for (int l = 0; l < 2; l++) if (wr_en[l]) begin
         if (wr_addr[l] == 5'd4 && wr_data[l][0]) cm = 1'b1;
         if (wr_addr[l] == 5'd1 || wr_addr[l] == 5'd2) tw = 1'b1;
      end
      m_ev_valid = cm;
      if (cm) begin
         m_ev_chan = m_chan; m_ev_ts = m_ts; m_ev_addr = m_addr; m_ev_data = m_packed();
      end
      if (tw) begin
         m_addr = '0;
         for (int k = 0; k < 4; k++) m_data[k] = '0;
      end
      for (int l = 0; l < 2; l++) if (wr_en[l]) begin
         case (int'(wr_addr[l]))
            0: m_chan = wr_data[l][7:0];
            1: m_ts[63:32] = wr_data[l];
            2: m_ts[31:0] = wr_data[l];
            3: m_addr = wr_data[l][15:0];
            8, 9, 10, 11: m_data[int'(wr_addr[l]) - 8] = wr_data[l];
            default: ;
         endcase
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic [1:0] e, input logic [4:0] a0, input logic [31:0] d0,
                       input logic [4:0] a1, input logic [31:0] d1, input logic [4:0] ra);
      wr_en = e; wr_addr[0] = a0; wr_data[0] = d0; wr_addr[1] = a1; wr_data[1] = d1;
      rd_addr = ra;
      @(posedge clk);
      model_edge();
      #1;
      chk("R6", "ev_valid", 128'(ev_valid), 128'(m_ev_valid));
      if (m_ev_valid) begin
         chk("R6", "ev_chan", 128'(ev_chan), 128'(m_ev_chan));
         chk("R6", "ev_ts", 128'(ev_ts), 128'(m_ev_ts));
         chk("R6", "ev_addr", 128'(ev_addr), 128'(m_ev_addr));
         chk("R8", "ev_data", ev_data, m_ev_data);
      end
      chk("R2", "rd_data", 128'(rd_data), 128'(m_read(int'(ra))));
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      step(2'b01, a, d, 5'd0, 32'd0, a);
   endtask

   task automatic rd_now(input string req, input int a, input logic [31:0] exp);
      rd_addr = 5'(a);
      #1;
      chk(req, $sformatf("read offset %0d", a), 128'(rd_data), 128'(exp));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 32; a++) rd_now("R1", a, 32'd0);
      chk("R1", "ev_valid after reset", 128'(ev_valid), 128'd0);

      // R2: every mapped register round-trips, wide values trimmed to field width
      wr(5'd0, 32'hFFFF_FFA5);
      wr(5'd1, 32'h1122_3344);
      wr(5'd2, 32'h5566_7788);
      wr(5'd3, 32'hABCD_1234);
      for (int k = 8; k < 12; k++) wr(5'(k), 32'hD000_0000 + 32'(k));
      rd_now("R2", 0, 32'h0000_00A5);
      rd_now("R2", 3, 32'h0000_1234);
      rd_now("R8", 11, 32'hD000_000B);

      // R3: timestamp write wipes address and data
      wr(5'd2, 32'h0000_0100);
      rd_now("R3", 3, 32'd0);
      for (int k = 8; k < 12; k++) rd_now("R3", k, 32'd0);
      rd_now("R3", 1, 32'h1122_3344);

      // R8: single word lands in the least significant position
      wr(5'd11, 32'hCAFE_F00D);
      step(2'b01, 5'd4, 32'd1, 5'd0, 32'd0, 5'd11);
      chk("R8", "single-word event", ev_data, {96'b0, 32'hCAFE_F00D});
      chk("R8", "single-word ts", 128'(ev_ts), 128'(64'h1122_3344_0000_0100));

      // R4: timestamp on lane 0 with a data and address write on lane 1
      wr(5'd9, 32'h1234_5678);
      step(2'b11, 5'd1, 32'h0000_0009, 5'd10, 32'hBEEF_0001, 5'd10);
      rd_now("R4", 10, 32'hBEEF_0001);
      rd_now("R4", 9, 32'd0);
      rd_now("R4", 11, 32'd0);
      step(2'b11, 5'd2, 32'h0000_0002, 5'd3, 32'h0000_7777, 5'd3);
      rd_now("R4", 3, 32'h0000_7777);
      rd_now("R4", 10, 32'd0);

      // R5: both lanes on one offset
      step(2'b11, 5'd8, 32'h1111_1111, 5'd8, 32'h2222_2222, 5'd8);
      rd_now("R5", 8, 32'h2222_2222);

      // R6: commit together with a data write on the other lane carries old data
      step(2'b11, 5'd4, 32'd1, 5'd8, 32'h3333_3333, 5'd8);
      chk("R6", "commit ignores same-cycle write", ev_data[127:96], 128'(32'h2222_2222));
      step(2'b00, 5'd0, 32'd0, 5'd0, 32'd0, 5'd8);
      chk("R6", "pulse is one cycle", 128'(ev_valid), 128'd0);
      step(2'b01, 5'd4, 32'hFFFF_FFFE, 5'd0, 32'd0, 5'd4);
      chk("R6", "bit0 clear gives no pulse", 128'(ev_valid), 128'd0);

      // R7: ganged commits with only the channel changed
      for (int c = 0; c < 3; c++) begin
         wr(5'd0, 32'(8'h10 + c));
         step(2'b01, 5'd4, 32'd1, 5'd0, 32'd0, 5'd8);
         chk("R7", "ganged channel", 128'(ev_chan), 128'(8'h10 + c));
         chk("R7", "ganged data", ev_data, {32'h3333_3333, 96'b0});
         chk("R7", "ganged addr", 128'(ev_addr), 128'(16'h7777));
      end
      rd_now("R7", 8, 32'h3333_3333);

      // R9: status follows the downstream flags in the same cycle
      for (int s = 0; s < 4; s++) begin
         dn_full = s[0]; dn_underflow = s[1];
         rd_now("R9", 5, {30'b0, s[1], s[0]});
      end

      // R10: unmapped and status offsets ignore writes
      wr(5'd20, 32'hFFFF_FFFF);
      wr(5'd5, 32'hFFFF_FFFF);
      wr(5'd7, 32'hFFFF_FFFF);
      dn_full = 1'b0; dn_underflow = 1'b0;
      rd_now("R10", 20, 32'd0);
      rd_now("R10", 7, 32'd0);
      rd_now("R10", 5, 32'd0);
      rd_now("R10", 3, 32'h0000_7777);
      rd_now("R10", 8, 32'h3333_3333);

      // mixed traffic compared with the model on every clock
      for (int n = 0; n < 400; n++) begin
         logic [4:0] pick [11] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5,
                                  5'd8, 5'd9, 5'd10, 5'd11, 5'd20};
         dn_full = 1'($urandom); dn_underflow = 1'($urandom);
         step(2'($urandom), pick[$urandom % 11], $urandom, pick[$urandom % 11], $urandom,
              pick[$urandom % 11]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule